// File: doc/BRIEF.md
# Two-Compare PWM Timer Channel

This block is one timer channel that turns a counter and two compare registers into a pulse-width modulated waveform on a single pin. The counter advances on a chosen edge of one of several prescaled clock sources, which arrive as slow level signals synchronous to the system clock. One compare register can be chosen to clear the counter, which fixes the period. The other register fixes the duty point, where the pin switches to a second programmable level.

Software programs the channel through a small write port. The usual sequence is as follows. Choose the source and edge, then the clearing register, then the pin levels, then the period and duty values, and then enable PWM mode. Last, set the start bit. The counter value is visible on an output so that the host can read it.

Register map (write address, field bits):
- address 0, control: [2:0] source select, [4:3] edge (00 rising, 01 falling, 10 or 11 both), [6:5] clear source (01 register A, 10 register B, 00 or 11 none), [7] PWM mode enable
- address 1, levels: [0] initial pin level, [1] level on an A match, [2] level on a B match
- address 2: counter value
- address 3: compare register A
- address 4: compare register B
- address 5: [0] start

Top module: `pwm2cmp_timer`

## Requirements
- R1: After reset the counter is 0, the pin is 0 and the channel is stopped, so source edges do not move the counter.
- R2: The counter changes only on a selected tick while start is 1. While start is 0, source edges change neither the counter nor the pin.
- R3: A tick is an edge of src_clk[select]: a rising edge for edge code 00, a falling edge for 01, and either edge for 10 or 11. A tick appears on the counter at the clock edge that samples the source change. Edges on unselected sources are ignored.
- R4: On a tick the counter clears to 0 if it equals the clearing register (clear code 01 selects A, 10 selects B). Otherwise it increments and wraps. With clear code 00 it never clears on a match.
- R5: In PWM mode, a tick that finds the counter equal to register A drives the pin to the A level. A tick that finds it equal to register B drives the pin to the B level.
- R6: When A and B match on the same tick, the level of the clearing register wins. With no clearing register, the A level wins.
- R7: Writing the levels register while stopped loads the pin with the initial level bit. Written while running, that bit has no effect on the pin.
- R8: A duty value above the period value never matches, so the pin keeps the level set by the period match.
- R9: Writing the counter while stopped sets the value from which counting resumes.
- R10: With PWM mode off, compare matches leave the pin unchanged, while counter clearing still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_clk | input | NSRC | Prescaled clock sources, as levels synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | Waveform pin |
| cnt_out | output | W | Current counter value |

## Verification
The two functions that can fall in the same cycle are the clearing match and the duty match. The bench makes them coincide by writing A and B to the same value. It then runs the counter up to that value once with A as the clearing register and once with B. The pin must take the clearing register's level, and the counter must return to 0 on that same tick. A duty value above the period is also run, to show that the duty point can never be reached.

// File: rtl/pwm2cmp_timer.sv
module pwm2cmp_timer #(
  parameter int W    = 16,
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  output logic            pwm_out,
  output logic [W-1:0]    cnt_out
);
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_LVL = 3'd1, AD_CNT = 3'd2,
                         AD_A = 3'd3, AD_B = 3'd4, AD_RUN = 3'd5;
  localparam logic [1:0] CLR_A = 2'b01, CLR_B = 2'b10;

  logic [SELW-1:0] csel;
  logic [1:0]      edg, clr;
  logic            pwm_en, lv_a, lv_b, run, src_q, pin;
  logic [W-1:0]    cnt, rega, regb;

  wire cur     = src_clk[csel];
  wire rise    = cur & ~src_q;
  wire fall    = ~cur & src_q;
  wire edge_hit = edg[1] ? (rise | fall) : (edg[0] ? fall : rise);
  wire tick    = run & edge_hit;
  wire hit_a   = (cnt == rega);
  wire hit_b   = (cnt == regb);
  wire clr_hit = ((clr == CLR_A) & hit_a) | ((clr == CLR_B) & hit_b);
  wire wr_cnt  = wr_en && wr_addr == AD_CNT;
  wire wr_lvl  = wr_en && wr_addr == AD_LVL;
  wire unused_ok = ^{wr_data[W-1:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csel <= '0; edg <= '0; clr <= '0; pwm_en <= 1'b0;
      lv_a <= 1'b0; lv_b <= 1'b0; run <= 1'b0;
      rega <= '0; regb <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AD_CTRL: begin
          csel   <= wr_data[SELW-1:0];
          edg    <= wr_data[4:3];
          clr    <= wr_data[6:5];
          pwm_en <= wr_data[7];
        end
        AD_LVL: begin
          lv_a <= wr_data[1];
          lv_b <= wr_data[2];
        end
        AD_A:   rega <= wr_data;
        AD_B:   regb <= wr_data;
        AD_RUN: run  <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= wr_data;
    else if (tick)   cnt <= clr_hit ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pin <= 1'b0;
    else if (wr_lvl && !run)
      pin <= wr_data[0];
    else if (tick && pwm_en) begin
      if (clr == CLR_B && hit_b) pin <= lv_b;
      else if (hit_a)            pin <= lv_a;
      else if (hit_b)            pin <= lv_b;
    end
  end

  assign pwm_out = pin;
  assign cnt_out = cnt;

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> ($stable(cnt_out) && $stable(pwm_out))); // R2
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_out)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_hit && !wr_cnt) |=> cnt_out == W'($past(cnt_out) + 1'b1)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_hit && !wr_cnt) |=> cnt_out == '0); // R4
  AST_A_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_en && hit_a && !hit_b && !wr_en) |=> pwm_out == $past(lv_a)); // R5
  AST_SAME_TICK_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_en && hit_a && hit_b && clr == CLR_B && !wr_en) |=> pwm_out == $past(lv_b)); // R6
  AST_PIN_HOLD_NONPWM: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && !wr_en) |=> $stable(pwm_out)); // R10
endmodule

// File: tb/tb_pwm2cmp_timer.sv
`timescale 1ns/1ps
module tb_pwm2cmp_timer;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] src_clk = '0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_out;
  logic [W-1:0] cnt_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm2cmp_timer #(.W(W), .NSRC(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .cnt_out(cnt_out));

  typedef struct packed {
    logic [15:0] a; logic [15:0] b; logic init; logic [7:0] n;
    logic [15:0] ecnt; logic eout;
  } vec_t;
  localparam vec_t VEC [9] = '{
    '{16'd5, 16'd2, 1'b0, 8'd3, 16'd3, 1'b1},
    '{16'd5, 16'd2, 1'b0, 8'd6, 16'd0, 1'b0},
    '{16'd5, 16'd2, 1'b0, 8'd9, 16'd3, 1'b1},
    '{16'd3, 16'd0, 1'b0, 8'd1, 16'd1, 1'b1},
    '{16'd3, 16'd0, 1'b0, 8'd4, 16'd0, 1'b0},
    '{16'd3, 16'd9, 1'b1, 8'd2, 16'd2, 1'b1},
    '{16'd3, 16'd9, 1'b1, 8'd7, 16'd3, 1'b0},
    '{16'd4, 16'd4, 1'b1, 8'd4, 16'd4, 1'b1},
    '{16'd4, 16'd4, 1'b1, 8'd5, 16'd0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_clk[idx] = 1'b1;
      @(negedge clk); src_clk[idx] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic setup(input int ctrl, input int lvl, input int a, input int b);
    wr(5, 0); wr(0, ctrl); wr(1, lvl); wr(2, 0); wr(3, a); wr(4, b);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt", cnt_out, 0);
    chk("R1 pin", pwm_out, 0);
    pulse(0, 3);
    chk("R1 stopped", cnt_out, 0);

    // table: rising on source 0, clear on A, A level 0, B level 1
    for (int v = 0; v < 9; v++) begin
      setup(8'hA0, 4 | VEC[v].init, VEC[v].a, VEC[v].b);
      wr(5, 1);
      pulse(0, VEC[v].n);
      chk($sformatf("R4 R5 R6 R8 vec%0d cnt", v), cnt_out, VEC[v].ecnt);
      chk($sformatf("R4 R5 R6 R8 vec%0d pin", v), pwm_out, VEC[v].eout);
    end

    // R9 resume from written counter
    setup(8'hA0, 5, 5, 2);
    wr(2, 4);
    chk("R9 written", cnt_out, 4);
    wr(5, 1);
    pulse(0, 1);
    chk("R9 resume", cnt_out, 5);
    chk("R9 pin", pwm_out, 1);
    pulse(0, 1);
    chk("R5 period clear cnt", cnt_out, 0);
    chk("R5 period pin", pwm_out, 0);
    pulse(0, 3);
    wr(5, 0);
    pulse(0, 3);
    chk("R2 frozen cnt", cnt_out, 3);
    chk("R2 frozen pin", pwm_out, 1);

    // R3 falling edge
    setup(8'hA8, 4, 100, 90);
    wr(5, 1);
    @(negedge clk); src_clk[0] = 1'b1;
    @(negedge clk);
    chk("R3 rise ignored", cnt_out, 0);
    src_clk[0] = 1'b0;
    @(negedge clk);
    chk("R3 fall counts", cnt_out, 1);
    // R3 both edges
    setup(8'hB0, 4, 100, 90);
    wr(5, 1);
    pulse(0, 1);
    chk("R3 both edges", cnt_out, 2);
    // R3 source select
    setup(8'hA1, 4, 100, 90);
    wr(5, 1);
    pulse(0, 2);
    chk("R3 other source ignored", cnt_out, 0);
    pulse(1, 2);
    chk("R3 selected source", cnt_out, 2);

    // R4 clear on B
    setup(8'hC0, 2, 2, 5);
    wr(5, 1);
    pulse(0, 3);
    chk("R4 clrB cnt", cnt_out, 3);
    chk("R5 A level", pwm_out, 1);
    pulse(0, 3);
    chk("R4 clrB clear", cnt_out, 0);
    chk("R5 B level", pwm_out, 0);
    // R4 no clear
    setup(8'h80, 5, 3, 20);
    wr(5, 1);
    pulse(0, 6);
    chk("R4 no clear", cnt_out, 6);
    chk("R5 A level no clear", pwm_out, 0);
    // R6 both hit, B clears
    setup(8'hC0, 3, 2, 2);
    wr(5, 1);
    pulse(0, 3);
    chk("R6 clrB cnt", cnt_out, 0);
    chk("R6 clrB pin", pwm_out, 0);
    // R10 PWM mode off
    setup(8'h20, 5, 3, 1);
    wr(5, 1);
    pulse(0, 5);
    chk("R10 clear still works", cnt_out, 1);
    chk("R10 pin held", pwm_out, 1);

    // R7 levels load
    wr(5, 0);
    wr(1, 0);
    chk("R7 load 0", pwm_out, 0);
    wr(1, 1);
    chk("R7 load 1", pwm_out, 1);
    wr(5, 1);
    wr(1, 0);
    chk("R7 ignored while running", pwm_out, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule